// File: doc/BRIEF.md
# Clock Lock Monitor with Hysteresis

This block decides, from timing alone, whether a feedback clock is phase-locked to a reference clock. A fast sampling clock drives all of its logic. Both monitored clocks are brought into that domain through synchronizers, and their rising edges are turned into single-cycle pulses. For every reference edge the block finds the nearest feedback edge, before or after it, and counts the distance in sampling ticks. Each such distance gives one verdict: good, marginal or bad.

A loss-of-lock flag reads 1 when out of lock and 0 when locked. It uses hysteresis. A large gap sets the flag, and only a small gap clears it. Gaps between the two thresholds leave the flag as it is. Once the flag is set it stays high for a minimum time. For sequencers further down the chain the block also gives a one-cycle strobe for each good verdict, a saturating count of consecutive good verdicts, and a flag that shows when that count has reached a set run length. All thresholds are given in picoseconds and converted to ticks using the sampling period parameter.

Top module: `lock_monitor`

## Requirements
- R1: Each input passes through a two-stage synchronizer and a rising-edge detector. With rising edges on both inputs first sampled at clock edge n, `win_good_o` is 0 after edges n and n+1 and is 1 after edge n+2.
- R2: Tick thresholds are the ceiling of picoseconds divided by SAMPLE_PS: assert 8, release 4 and hold 20 at the defaults. The gap for a reference edge is the distance in ticks to the nearest feedback edge, whether that edge came before the reference edge or after it. A feedback edge up to 3 ticks before the reference edge therefore counts as good.
- R3: A gap above the assert threshold (more than 8 ticks) is a bad verdict, and `lol_o` is 1 from the next cycle. A reference edge with no feedback edge within 8 ticks on either side counts as bad. This covers a stopped feedback clock.
- R4: A gap below the release threshold (under 4 ticks) is a good verdict. It drives `lol_o` to 0 if the hold window has expired.
- R5: A gap of 4 to 8 ticks inclusive is marginal and leaves `lol_o` unchanged, whether it was 0 or 1.
- R6: After each bad verdict `lol_o` stays 1 for at least 20 cycles. Good verdicts inside that window are ignored, and a further bad verdict restarts the window.
- R7: `win_good_o` pulses for exactly one cycle after each good verdict, in the same cycle that `lol_o` and the count change.
- R8: `good_cnt_o` increments on each good verdict, saturates at 15 and returns to 0 on any marginal or bad verdict.
- R9: `good_run_o` is 1 exactly when `good_cnt_o` is 8 or more.
- R10: While `rst_n` is 0: `lol_o`=1, `win_good_o`=0, `good_cnt_o`=0 and `good_run_o`=0.
- R11: A reference edge that arrives while an earlier measurement is still waiting for its feedback edge discards that measurement without a verdict. A reference clock faster than 10 ticks per period with no feedback therefore leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| ref_clk_i | input | 1 | Reference clock, asynchronous to clk |
| fb_clk_i | input | 1 | Feedback clock, asynchronous to clk |
| lol_o | output | 1 | Loss of lock: 1 out of lock, 0 locked |
| win_good_o | output | 1 | One-cycle strobe for each good verdict |
| good_cnt_o | output | CNT_W | Saturating count of consecutive good verdicts |
| good_run_o | output | 1 | Consecutive good count has reached RUN_LEN |

## Verification
Two situations can land in the same cycle. In the first, a good verdict arrives on the last cycle of a hold window. In the second, a new reference edge arrives while the previous measurement is still waiting. To provoke the first, the bench alternates bursts with the feedback clock stopped and bursts with aligned clocks, and steps the period across several values, so that the first good verdict after a violation falls before the hold expires, on its last cycle, and after it. A behavioural model with absolute tick stamps predicts every output on every clock, and an independent monitor measures each high run of the flag. For the second, the reference clock is run faster than the timeout while the feedback clock is stopped. Silence on every output is then the expected result.

// File: rtl/lkm_pkg.sv
package lkm_pkg;

  // Classification of one reference-edge measurement.
  typedef enum logic [1:0] {
    VERD_GOOD = 2'd0,
    VERD_MID  = 2'd1,
    VERD_BAD  = 2'd2
  } verdict_t;

  // Converts a duration in picoseconds to sampling ticks, rounding up.
  function automatic int ps_to_ticks(input int dur_ps, input int sample_ps);
    return (dur_ps + sample_ps - 1) / sample_ps;
  endfunction

endpackage

// File: rtl/lkm_edge_sync.sv
// Synchronizer chain followed by a rising-edge detector (R1).
module lkm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
      last_q <= chain_q[STAGES-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/lkm_gap_meter.sv
// Measures, for every reference edge, the tick distance to the nearest
// feedback edge on either side and classifies it (R2, R3, R11).
module lkm_gap_meter
  import lkm_pkg::*;
#(
  parameter int REL_T    = 4,
  parameter int ASSERT_T = 8,
  parameter int GAP_W    = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ref_rise,
  input  logic     fb_rise,
  output logic     dec_vld,
  output verdict_t dec_cls
);

  localparam logic [GAP_W-1:0] SAT_L = GAP_W'(ASSERT_T + 1);
  localparam logic [GAP_W-1:0] REL_L = GAP_W'(REL_T);
  localparam logic [GAP_W-1:0] ASR_L = GAP_W'(ASSERT_T);
  localparam logic [GAP_W-1:0] ONE_L = GAP_W'(1);

  logic [GAP_W-1:0] age_q, age_d;   // ticks since last feedback edge, saturating
  logic [GAP_W-1:0] ra_q, ra_d;     // backward distance captured at reference edge
  logic [GAP_W-1:0] b_q, b_d;       // ticks elapsed since pending reference edge
  logic             pend_q, pend_d;
  logic [GAP_W-1:0] a_now;
  logic [GAP_W-1:0] gap;
  logic             meas_en;

  always_comb begin
    age_d   = fb_rise ? ONE_L : ((age_q >= SAT_L) ? SAT_L : age_q + ONE_L);
    a_now   = fb_rise ? '0 : age_q;
    pend_d  = pend_q;
    ra_d    = ra_q;
    b_d     = b_q;
    dec_vld = 1'b0;
    gap     = '0;
    if (ref_rise) begin
      // A new reference edge supersedes any waiting measurement (R11).
      if (a_now == '0) begin
        dec_vld = 1'b1;
        pend_d  = 1'b0;
      end else begin
        pend_d = 1'b1;
        ra_d   = a_now;
        b_d    = ONE_L;
      end
    end else if (pend_q) begin
      if (fb_rise) begin
        dec_vld = 1'b1;
        gap     = (b_q < ra_q) ? b_q : ra_q;
        pend_d  = 1'b0;
      end else if (b_q >= ra_q) begin
        // Nothing closer can still arrive; includes the timeout (R3).
        dec_vld = 1'b1;
        gap     = ra_q;
        pend_d  = 1'b0;
      end else begin
        b_d = b_q + ONE_L;
      end
    end
    if (gap < REL_L)      dec_cls = VERD_GOOD;
    else if (gap > ASR_L) dec_cls = VERD_BAD;
    else                  dec_cls = VERD_MID;
  end

  assign meas_en = ref_rise | pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= SAT_L;
      pend_q <= 1'b0;
      ra_q   <= '0;
      b_q    <= '0;
    end else begin
      age_q  <= age_d;
      pend_q <= pend_d;
      if (meas_en) begin
        ra_q <= ra_d;
        b_q  <= b_d;
      end
    end
  end

  // Coincident edges always give an immediate good verdict (R2).
  assert_aligned_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise) |-> (dec_vld && dec_cls == VERD_GOOD));

endmodule

// File: rtl/lkm_lol_flag.sv
// Hysteretic loss-of-lock flag with retriggerable minimum high time.
module lkm_lol_flag
  import lkm_pkg::*;
#(
  parameter int HOLD_T = 20,
  parameter int HOLD_W = 5
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dec_vld,
  input  verdict_t dec_cls,
  output logic     lol
);

  localparam logic [HOLD_W-1:0] HOLD_L   = HOLD_W'(HOLD_T);
  localparam logic [HOLD_W-1:0] RELOAD_L = HOLD_W'(HOLD_T - 1);
  localparam logic [HOLD_W-1:0] ONE_L    = HOLD_W'(1);

  logic              lol_q, lol_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic              hold_en;
  logic              is_bad, is_good;

  assign is_bad  = dec_vld && (dec_cls == VERD_BAD);
  assign is_good = dec_vld && (dec_cls == VERD_GOOD);

  always_comb begin
    lol_d   = lol_q;
    hold_en = is_bad || (hold_q != '0);
    hold_d  = is_bad ? RELOAD_L : hold_q - ONE_L;
    if (is_bad) begin
      lol_d = 1'b1;                          // R3, R6 retrigger
    end else if (is_good && hold_q == '0) begin
      lol_d = 1'b0;                          // R4
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lol_q  <= 1'b1;                        // R10
      hold_q <= '0;
    end else begin
      lol_q <= lol_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign lol = lol_q;

  // Checker-side counter of cycles since the last bad verdict.
  logic [HOLD_W-1:0] chk_since_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_since_q <= HOLD_L;
    end else if (is_bad) begin
      chk_since_q <= ONE_L;
    end else if (chk_since_q != HOLD_L) begin
      chk_since_q <= chk_since_q + ONE_L;
    end
  end

  assert_bad_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_bad |=> lol_q);

  assert_mid_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_cls == VERD_MID) |=> $stable(lol_q));

  assert_min_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lol_q) |-> (chk_since_q >= HOLD_L));

endmodule

// File: rtl/lkm_good_run.sv
// Good-verdict strobe and saturating consecutive-good counter.
module lkm_good_run
  import lkm_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int RUN_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_vld,
  input  verdict_t         dec_cls,
  output logic             win_good,
  output logic [CNT_W-1:0] cnt,
  output logic             run_met
);

  localparam logic [CNT_W-1:0] MAX_L = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] RUN_L = CNT_W'(RUN_LEN);
  localparam logic [CNT_W-1:0] ONE_L = CNT_W'(1);

  logic             stb_q, stb_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             good;

  assign good = dec_vld && (dec_cls == VERD_GOOD);

  always_comb begin
    stb_d = good;                            // R7
    if (good) cnt_d = (cnt_q == MAX_L) ? MAX_L : cnt_q + ONE_L;
    else      cnt_d = '0;                    // R8
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      stb_q <= stb_d;
      if (dec_vld) cnt_q <= cnt_d;
    end
  end

  assign win_good = stb_q;
  assign cnt      = cnt_q;
  assign run_met  = (cnt_q >= RUN_L);        // R9

  assert_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    good |=> stb_q);

  assert_nongood_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && dec_cls != VERD_GOOD) |=> (cnt_q == '0));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (good && cnt_q == MAX_L) |=> (cnt_q == MAX_L));

endmodule

// File: rtl/lock_monitor.sv
module lock_monitor
  import lkm_pkg::*;
#(
  parameter int SAMPLE_PS   = 500,
  parameter int ASSERT_PS   = 4000,
  parameter int RELEASE_PS  = 2000,
  parameter int MIN_HIGH_PS = 10000,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int RUN_LEN     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk_i,
  input  logic             fb_clk_i,
  output logic             lol_o,
  output logic             win_good_o,
  output logic [CNT_W-1:0] good_cnt_o,
  output logic             good_run_o
);

  localparam int ASSERT_T = ps_to_ticks(ASSERT_PS, SAMPLE_PS);
  localparam int REL_T    = ps_to_ticks(RELEASE_PS, SAMPLE_PS);
  localparam int HOLD_T   = ps_to_ticks(MIN_HIGH_PS, SAMPLE_PS);
  localparam int GAP_W    = $clog2(ASSERT_T + 2);
  localparam int HOLD_W   = $clog2(HOLD_T + 1);

  logic [1:0] raw_in;
  logic [1:0] rise;
  logic       dec_vld;
  verdict_t   dec_cls;

  assign raw_in = {fb_clk_i, ref_clk_i};

  // One synchronizer/edge detector per monitored clock (R1).
  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    lkm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_in[ch]),
      .rise (rise[ch])
    );
  end

  lkm_gap_meter #(
    .REL_T   (REL_T),
    .ASSERT_T(ASSERT_T),
    .GAP_W   (GAP_W)
  ) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_rise(rise[0]),
    .fb_rise (rise[1]),
    .dec_vld (dec_vld),
    .dec_cls (dec_cls)
  );

  lkm_lol_flag #(
    .HOLD_T(HOLD_T),
    .HOLD_W(HOLD_W)
  ) u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .dec_vld(dec_vld),
    .dec_cls(dec_cls),
    .lol    (lol_o)
  );

  lkm_good_run #(
    .CNT_W  (CNT_W),
    .RUN_LEN(RUN_LEN)
  ) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .dec_vld (dec_vld),
    .dec_cls (dec_cls),
    .win_good(win_good_o),
    .cnt     (good_cnt_o),
    .run_met (good_run_o)
  );

  // The run flag can only come up together with a good strobe (R9).
  assert_run_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(good_run_o) |-> win_good_o);

endmodule

// File: tb/lock_monitor_tb_top.sv
module lock_monitor_tb_top;

  localparam int ASSERT_T = 8;
  localparam int REL_T    = 4;
  localparam int HOLD_T   = 20;
  localparam int SAT_T    = ASSERT_T + 1;
  localparam int CNT_MAX  = 15;
  localparam int RUN_LEN  = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_drv, fb_drv;
  logic       lol, win_good, good_run;
  logic [3:0] good_cnt;

  always #5 clk = ~clk;

  lock_monitor dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_clk_i (ref_drv),
    .fb_clk_i  (fb_drv),
    .lol_o     (lol),
    .win_good_o(win_good),
    .good_cnt_o(good_cnt),
    .good_run_o(good_run)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    tk = 0;
  bit    cmp_en = 0;
  string lol_tag = "R10";

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (time %0t)", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model (absolute tick stamps)
  int q, lf, rtick, ra, lastv, m_cnt, gap, a, b;
  bit have_lf, pend, m_lol, m_win, dec, er, ef;
  bit hr[4];
  bit hf[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      q = 0; have_lf = 0; pend = 0; lastv = -100000;
      m_lol = 1; m_win = 0; m_cnt = 0;
      for (int i = 0; i < 4; i++) begin hr[i] = 0; hf[i] = 0; end
    end else begin
      q++;
      for (int i = 3; i > 0; i--) begin hr[i] = hr[i-1]; hf[i] = hf[i-1]; end
      hr[0] = ref_drv; hf[0] = fb_drv;
      er = hr[2] && !hr[3];
      ef = hf[2] && !hf[3];
      dec = 0; gap = 0;
      if (er) begin
        if (ef) a = 0;
        else if (have_lf) a = (q - lf < SAT_T) ? q - lf : SAT_T;
        else a = SAT_T;
        if (a == 0) begin dec = 1; gap = 0; pend = 0; end
        else begin pend = 1; rtick = q; ra = a; end
      end else if (pend) begin
        b = q - rtick;
        if (ef) begin dec = 1; gap = (b < ra) ? b : ra; pend = 0; end
        else if (b >= ra) begin dec = 1; gap = ra; pend = 0; end
      end
      if (ef) begin lf = q; have_lf = 1; end
      m_win = dec && (gap < REL_T);
      if (dec) begin
        if (gap > ASSERT_T) begin m_lol = 1; lastv = q; end
        else if (gap < REL_T && q - lastv >= HOLD_T) m_lol = 0;
        m_cnt = (gap < REL_T) ? ((m_cnt < CNT_MAX) ? m_cnt + 1 : CNT_MAX) : 0;
      end
    end
  end

  // ---------------- per-clock comparison and independent monitors
  int hi_run = 0;
  bit hi_armed = 0;
  int win_seen = 0;

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      check(lol_tag, "lol", lol, m_lol);
      check("R7", "win_good", win_good, m_win);
      check("R8", "good_cnt", good_cnt, m_cnt);
      check("R9", "good_run", good_run, (m_cnt >= RUN_LEN) ? 1 : 0);
      if (win_good) win_seen++;
      if (lol) hi_run++;
      else begin
        if (hi_armed && hi_run > 0) check("R6", "lol high run >= hold", (hi_run >= HOLD_T) ? 1 : 0, 1);
        hi_run = 0;
        hi_armed = 1;
      end
    end
  end

  task automatic run_pat(input int rper, input int fper, input int off, input bit fb_on, input int n);
    tk = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ref_drv = ((tk % rper) < rper / 2);
      fb_drv  = fb_on && (((tk + 10000 * fper - off) % fper) < fper / 2);
      tk++;
    end
  endtask

  // ---------------- watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  // ---------------- stimulus
  initial begin
    rst_n = 1'b0; ref_drv = 1'b0; fb_drv = 1'b0;
    repeat (4) @(negedge clk);
    check("R10", "lol in reset", lol, 1);
    check("R10", "win_good in reset", win_good, 0);
    check("R10", "good_cnt in reset", good_cnt, 0);
    check("R10", "good_run in reset", good_run, 0);
    rst_n = 1'b1;
    cmp_en = 1;
    repeat (3) @(negedge clk);

    // R1: latency through synchronizers and edge detectors
    lol_tag = "R1";
    ref_drv = 1'b1; fb_drv = 1'b1;
    @(negedge clk); check("R1", "win_good after edge n", win_good, 0);
    @(negedge clk); check("R1", "win_good after edge n+1", win_good, 0);
    @(negedge clk); check("R1", "win_good after edge n+2", win_good, 1);
    ref_drv = 1'b0; fb_drv = 1'b0;
    repeat (20) @(negedge clk);

    // R4: aligned clocks lock and fill the counter
    lol_tag = "R4";
    run_pat(40, 40, 0, 1, 800);
    check("R4", "lol after aligned run", lol, 0);
    check("R8", "count saturated", good_cnt, CNT_MAX);
    check("R9", "run flag after long good run", good_run, 1);

    // R2: feedback leading by 3 ticks is still good
    lol_tag = "R2";
    run_pat(40, 40, -3, 1, 800);
    check("R2", "lol with feedback leading", lol, 0);
    check("R2", "count with feedback leading", good_cnt, CNT_MAX);

    // R5: marginal gap keeps the locked state
    lol_tag = "R5";
    run_pat(40, 40, 6, 1, 400);
    check("R5", "lol held low on marginal gap", lol, 0);
    check("R8", "count cleared by marginal gap", good_cnt, 0);

    // R3: large gap sets the flag
    lol_tag = "R3";
    run_pat(40, 40, 12, 1, 400);
    check("R3", "lol on large gap", lol, 1);

    // R5: marginal gap keeps the unlocked state
    lol_tag = "R5";
    run_pat(40, 40, 6, 1, 400);
    check("R5", "lol held high on marginal gap", lol, 1);

    lol_tag = "R4";
    run_pat(40, 40, 0, 1, 400);
    check("R4", "lol cleared after relock", lol, 0);

    // R3: stopped feedback clock
    lol_tag = "R3";
    run_pat(40, 40, 0, 0, 400);
    check("R3", "lol with stopped feedback", lol, 1);
    check("R8", "count with stopped feedback", good_cnt, 0);

    // R6: hold window against early good verdicts, period sweep
    lol_tag = "R6";
    for (int per = 10; per <= 14; per++) begin
      run_pat(per, per, 0, 0, 3 * per);
      run_pat(per, per, 0, 1, 9 * per);
    end

    // R11: fast reference with no feedback yields no verdicts
    lol_tag = "R4";
    run_pat(40, 40, 0, 1, 800);
    check("R4", "lol before fast reference phase", lol, 0);
    lol_tag = "R11";
    win_seen = 0;
    run_pat(6, 6, 0, 0, 300);
    check("R11", "lol unchanged by superseded measurements", lol, 0);
    check("R11", "count unchanged by superseded measurements", good_cnt, CNT_MAX);
    check("R11", "no good strobes", win_seen, 0);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule